// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block builds a single-error-correct, double-error-detect parity code over the main area of one NAND page while the page streams past. Words enter on a valid/ready input, one per accepted beat, in order from the first word of the page. For every bit position inside a word it forms column parities. For every bit of the word index it forms line parities. Each parity exists in two forms. The true form covers the positions or words whose selecting bit is one. The complementary form covers those whose selecting bit is zero.

The page length is chosen on `page_sel`: 0, 1, 2 and 3 select 512, 1024, 2048 and 4096 words. The word width is chosen on `wide`: 0 gives 8-bit words and 1 gives 16-bit words. Both settings must stay constant from a `clear` until the page is finished. Pulsing `clear` zeroes the code and restarts at word index 0. After the last word of the page is absorbed, `done` rises and the code freezes until the next `clear`.

Back-pressure rules: a beat is taken on a clock edge where `in_valid` and `in_ready` are both high and `clear` is low. `in_ready` is high from reset or `clear` until the last word has been taken, and low while `done` is high. A beat offered together with `clear` is dropped. A source may hold `in_valid` low for any number of cycles between beats.

Top module: `nand_page_parity`

## Requirements
- R1: After reset, `par_true` and `par_comp` are zero, `done` is low and `in_ready` is high.
- R2: In 8-bit mode, column bits 0, 1 and 2 of the true word accumulate the XOR of the data bits whose position has bit 0, 1 or 2 set: P1 covers bits 7,5,3,1, P2 covers bits 7,6,3,2 and P4 covers bits 7..4. Column bits 0 to 2 of the complementary word cover the remaining bits. Column bit 3 of both words stays 0.
- R3: In 16-bit mode, column bits 0 to 3 use the same rule over bit positions 0 to 15.
- R4: Line bit k sits at bit position 4+k of each output word. The true word accumulates the XOR of all data bits of every word whose index has bit k set. The complementary word does the same for every word whose index has bit k clear.
- R5: Line bits k at or above 9+`page_sel` stay 0 in both words.
- R6: `done` rises in the cycle after the beat carrying word index 512·2^`page_sel`−1 is accepted, and not before.
- R7: While `done` is high, offered beats are not taken and both output words hold.
- R8: `clear` zeroes both words and `done` on the next edge, and the next accepted beat is word index 0. A beat offered together with `clear` is dropped.
- R9: A cycle with `in_valid` low leaves both output words unchanged.
- R10: In 8-bit mode the upper byte of `in_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of accumulation |
| page_sel | input | 2 | Page length: 512 << page_sel words |
| wide | input | 1 | 1 for 16-bit words, 0 for 8-bit words |
| in_valid | input | 1 | Data beat offered |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 16 | Data word (low byte only in 8-bit mode) |
| done | output | 1 | Last main-area word absorbed; code frozen |
| par_true | output | 16 | {line P[11:0], column P[3:0]} |
| par_comp | output | 16 | {line P'[11:0], column P'[3:0]} |

## Verification
All parity state is visible at the ports in the cycle after each beat, so the code is compared against a running model after every cycle. A wrong column or line accumulator therefore shows up one cycle after the first beat it mishandles. A wrong word index or page-length decode shows up as a line-bit mismatch within two beats, or as a `done` edge one beat early or late. Stale state after `clear`, or a beat taken while frozen, appears as a non-zero or changed word on the following cycle.

// File: rtl/nand_par_pkg.sv
package nand_par_pkg;
  typedef enum logic {WMODE_NARROW = 1'b0, WMODE_WIDE = 1'b1} wmode_e;

  // number of index bits that carry line parity for a given size select
  function automatic int unsigned active_line_bits(input int unsigned base_log,
                                                   input int unsigned sel);
    return base_log + sel;
  endfunction
endpackage

// File: rtl/nand_word_fold.sv
module nand_word_fold #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  localparam int COL_W   = $clog2(DATA_W),
  localparam int NCOL_W  = $clog2(NARROW_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic              wide,
  output logic              wpar,
  output logic [COL_W-1:0]  col_p,
  output logic [COL_W-1:0]  col_n
);
  // mask of bit positions whose position number has bit j set
  function automatic logic [DATA_W-1:0] pos_mask(input int j);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = ((b >> j) & 1) == 1;
    return m;
  endfunction

  logic [DATA_W-1:0] eff;
  assign eff  = wide ? data : {{(DATA_W-NARROW_W){1'b0}}, data[NARROW_W-1:0]};
  assign wpar = ^eff;

  for (genvar j = 0; j < COL_W; j++) begin : g_col
    localparam logic [DATA_W-1:0] PM = pos_mask(j);
    assign col_p[j] = ^(eff & PM);
    if (j < NCOL_W) begin : g_both
      assign col_n[j] = ^(eff & ~PM);
    end else begin : g_wide_only
      assign col_n[j] = wide & (^(eff & ~PM));
    end
  end
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq #(
  parameter int BASE_LOG = 9,
  parameter int SEL_W    = 2,
  localparam int IDX_W   = BASE_LOG + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_valid,
  input  logic [SEL_W-1:0] page_sel,
  output logic             in_ready,
  output logic             done,
  output logic             accept,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W:0]   words;
  logic [IDX_W-1:0] last_idx;

  assign words    = (IDX_W+1)'(1) << (BASE_LOG + 32'(page_sel));
  assign last_idx = words[IDX_W-1:0] - IDX_W'(1);
  assign in_ready = ~done;
  assign accept   = in_valid & ~done & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (clear) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (accept) begin
      if (idx == last_idx) begin
        idx  <= '0;
        done <= 1'b1;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  assert_index_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> ({1'b0, idx} < words));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(accept) && ($past(idx) == $past(last_idx))));
endmodule

// File: rtl/nand_line_acc.sv
module nand_line_acc #(
  parameter int BASE_LOG = 9,
  parameter int SEL_W    = 2,
  localparam int IDX_W   = BASE_LOG + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic             wpar,
  input  logic [IDX_W-1:0] idx,
  input  logic [SEL_W-1:0] page_sel,
  output logic [IDX_W-1:0] line_p,
  output logic [IDX_W-1:0] line_n
);
  import nand_par_pkg::*;

  logic [IDX_W-1:0] act;

  for (genvar k = 0; k < IDX_W; k++) begin : g_act
    assign act[k] = k < active_line_bits(BASE_LOG, 32'(page_sel));

    assert_inactive_line_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !act[k]) |-> (!line_p[k] && !line_n[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_p <= '0;
      line_n <= '0;
    end else if (clear) begin
      line_p <= '0;
      line_n <= '0;
    end else if (accept) begin
      for (int k = 0; k < IDX_W; k++) begin
        if (act[k]) begin
          if (idx[k]) line_p[k] <= line_p[k] ^ wpar;
          else        line_n[k] <= line_n[k] ^ wpar;
        end
      end
    end
  end
endmodule

// File: rtl/nand_page_parity.sv
module nand_page_parity #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int BASE_LOG = 9,
  parameter int SEL_W    = 2,
  localparam int IDX_W   = BASE_LOG + (1 << SEL_W) - 1,
  localparam int COL_W   = $clog2(DATA_W),
  localparam int PAR_W   = IDX_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [SEL_W-1:0]  page_sel,
  input  logic              wide,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              done,
  output logic [PAR_W-1:0]  par_true,
  output logic [PAR_W-1:0]  par_comp
);
  import nand_par_pkg::*;

  wmode_e           mode;
  logic             accept;
  logic [IDX_W-1:0] idx;
  logic             wpar;
  logic [COL_W-1:0] wcol_p, wcol_n;
  logic [COL_W-1:0] col_p_q, col_n_q;
  logic [IDX_W-1:0] line_p, line_n;

  assign mode = wmode_e'(wide);

  nand_page_seq #(.BASE_LOG(BASE_LOG), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .page_sel(page_sel), .in_ready(in_ready), .done(done),
    .accept(accept), .idx(idx)
  );

  nand_word_fold #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_fold (
    .data(in_data), .wide(mode == WMODE_WIDE), .wpar(wpar),
    .col_p(wcol_p), .col_n(wcol_n)
  );

  nand_line_acc #(.BASE_LOG(BASE_LOG), .SEL_W(SEL_W)) u_line (
    .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept), .wpar(wpar),
    .idx(idx), .page_sel(page_sel), .line_p(line_p), .line_n(line_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_p_q <= '0;
      col_n_q <= '0;
    end else if (clear) begin
      col_p_q <= '0;
      col_n_q <= '0;
    end else if (accept) begin
      col_p_q <= col_p_q ^ wcol_p;
      col_n_q <= col_n_q ^ wcol_n;
    end
  end

  assign par_true = {line_p, col_p_q};
  assign par_comp = {line_n, col_n_q};

  assert_frozen_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> ($stable(par_true) && $stable(par_comp)));

  assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (par_true == '0 && par_comp == '0 && !done));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clear) |=> ($stable(par_true) && $stable(par_comp)));

  assert_narrow_col3_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && $past(clear) && !wide) |=> (par_true[3] == 1'b0 && par_comp[3] == 1'b0));
endmodule

// File: tb/nand_page_parity_bench.sv
module nand_page_parity_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic [1:0]  page_sel = 2'd0;
  logic        wide = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = 16'h0;
  logic        in_ready, done;
  logic [15:0] par_true, par_comp;

  int total = 0;
  int bad = 0;

  logic [3:0]  e_cp, e_cn;
  logic [11:0] e_lp, e_ln;
  int          e_idx;
  bit          e_done;

  always #10 clk = ~clk;

  nand_page_parity u_nand_page_parity (
    .clk(clk), .rst_n(rst_n), .clear(clear), .page_sel(page_sel), .wide(wide),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .done(done),
    .par_true(par_true), .par_comp(par_comp)
  );

  function automatic logic [3:0] f_colp(input logic [15:0] d, input bit w);
    logic [3:0] r = '0;
    for (int pos = 0; pos < (w ? 16 : 8); pos++)
      for (int j = 0; j < 4; j++)
        if (((pos >> j) & 1) == 1) r[j] = r[j] ^ d[pos];
    return r;
  endfunction

  function automatic logic [3:0] f_coln(input logic [15:0] d, input bit w);
    logic [3:0] r = '0;
    for (int j = 0; j < (w ? 4 : 3); j++)
      for (int pos = 0; pos < (w ? 16 : 8); pos++)
        if (((pos >> j) & 1) == 0) r[j] = r[j] ^ d[pos];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " par_true"}, 32'(par_true), 32'({e_lp, e_cp}));
    chk({tag, " par_comp"}, 32'(par_comp), 32'({e_ln, e_cn}));
    chk({tag, " done"}, 32'(done), 32'(e_done));
    chk({tag, " in_ready"}, 32'(in_ready), 32'(!e_done));
  endtask

  task automatic model_clear();
    e_cp = '0; e_cn = '0; e_lp = '0; e_ln = '0; e_idx = 0; e_done = 0;
  endtask

  // drive one cycle (called at a negedge), then update the model
  task automatic step(input bit v, input logic [15:0] d, input bit c);
    bit acc;
    logic wp;
    int lw;
    in_valid = v; in_data = d; clear = c;
    acc = v && !e_done && !c;
    @(negedge clk);
    if (c) model_clear();
    else if (acc) begin
      lw = 9 + int'(page_sel);
      wp = ^(wide ? d : {8'h00, d[7:0]});
      e_cp ^= f_colp(d, wide);
      e_cn ^= f_coln(d, wide);
      for (int k = 0; k < lw; k++)
        if (((e_idx >> k) & 1) == 1) e_lp[k] = e_lp[k] ^ wp;
        else e_ln[k] = e_ln[k] ^ wp;
      e_idx++;
      if (e_idx == (512 << page_sel)) begin e_idx = 0; e_done = 1; end
    end
    in_valid = 1'b0; clear = 1'b0;
  endtask

  task automatic start_page(input logic [1:0] sel, input bit w);
    page_sel = sel; wide = w;
    step(0, 16'h0, 1);
    chk_all("R8 after clear");
  endtask

  task automatic run_page(input string tag);
    int guard = 0;
    while (!e_done && guard < 20000) begin
      step(($urandom % 4) != 0, 16'($urandom), 0);
      chk_all(tag);
      guard++;
    end
    chk({tag, " R6 done reached"}, 32'(done), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    #35;
    @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");

    // directed: single MSB in byte mode at index 0
    start_page(2'd0, 1'b0);
    step(1, 16'h0080, 0);
    chk("R2 true", 32'(par_true), 32'h0007);
    chk("R4 comp", 32'(par_comp), 32'h1FF0);

    // directed: bit 0 at index 1
    start_page(2'd0, 1'b0);
    step(1, 16'h0000, 0);
    step(1, 16'h0001, 0);
    chk("R4 true idx1", 32'(par_true), 32'h0010);
    chk("R2 comp idx1", 32'(par_comp), 32'h1FE7);

    // directed: 16-bit MSB
    start_page(2'd0, 1'b1);
    step(1, 16'h8000, 0);
    chk("R3 true", 32'(par_true), 32'h000F);
    chk("R3 comp", 32'(par_comp), 32'h1FF0);

    // directed: upper byte ignored in byte mode
    start_page(2'd0, 1'b0);
    step(1, 16'hFF00, 0);
    chk("R10 true", 32'(par_true), 32'h0000);
    chk("R10 comp", 32'(par_comp), 32'h0000);
    chk_all("R10 index advanced");

    // idle cycles keep state
    step(1, 16'h00A5, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 16'($urandom), 0);
      chk_all("R9 idle");
    end

    // clear together with a beat drops the beat
    step(1, 16'h00FF, 1);
    chk("R8 clear true", 32'(par_true), 32'h0);
    chk("R8 clear comp", 32'(par_comp), 32'h0);
    step(1, 16'h0001, 0);
    chk("R8 restart idx0 comp", 32'(par_comp), 32'h1FF7);

    // full random pages
    start_page(2'd0, 1'b0);
    run_page("R2 R4 page512 byte");
    chk("R5 page512", 32'(par_true[15:13] | par_comp[15:13]), 32'h0);
    for (int i = 0; i < 8; i++) begin
      step(1, 16'($urandom), 0);
      chk_all("R7 frozen");
    end

    start_page(2'd1, 1'b1);
    run_page("R3 R4 page1024 wide");
    chk("R5 page1024", 32'(par_true[15:14] | par_comp[15:14]), 32'h0);

    start_page(2'd2, 1'b0);
    for (int i = 0; i < 700; i++) begin
      step(($urandom % 3) != 0, 16'($urandom), 0);
      chk_all("R8 partial page");
    end
    start_page(2'd2, 1'b0);
    run_page("R6 page2048 byte");
    chk("R5 page2048", 32'(par_true[15] | par_comp[15]), 32'h0);

    start_page(2'd3, 1'b1);
    run_page("R6 page4096 wide");
    for (int i = 0; i < 4; i++) begin
      step(1, 16'hFFFF, 0);
      chk_all("R7 frozen 4096");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule